// File: doc/BRIEF.md
# Frame-End Alignment Character Inserter

This block sits on the transmit side of a serial converter link, just before the 8b/10b encoder. It receives data octets, one per valid cycle, grouped into frames of two octets (the high octet of a 14-bit sample, then the low octet). Frames are in turn grouped into multiframes of a parameterised number of frames. At the closing octet of each frame the block decides whether to swap that octet for a control character. The receiver uses that character to confirm it is still locked to the frame boundary.

Two mode inputs set the rule. When scrambling is disabled, a closing octet is swapped when it repeats the closing octet of the frame before. When scrambling is enabled, a closing octet is swapped when it already carries the data value of the matching control character. The lane-sync input selects whether a multiframe boundary gets its own character (0x7C) or every boundary uses 0xFC. The output octet leaves one cycle after its input, with a flag telling the encoder to send it as a control character.

Top module: `fai_inserter`

## Requirements
- R1: While reset is high, `out_valid` and `out_ctrl` are 0. After reset the first valid octet is taken as the opening octet of frame 0 of a multiframe.
- R2: Each valid input octet appears at the outputs exactly one clock later with `out_valid` high. An octet that does not close a frame passes unchanged with `out_ctrl` = 0.
- R3: A cycle with `in_valid` low produces `out_valid` low the next cycle and does not move the octet or frame position.
- R4: With scrambling off and lane sync off, a closing octet equal to the previous frame's closing octet is output as 0xFC with `out_ctrl` = 1, at any multiframe position. Otherwise it passes unchanged.
- R5: With scrambling off and lane sync on, a repeated closing octet is output as 0xFC with `out_ctrl` = 1, except at a multiframe end, where it is output as 0x7C with `out_ctrl` = 1.
- R6: The repeat comparison always uses the original closing octet of the previous frame, even if that octet was itself swapped.
- R7: With scrambling off, the closing octet of the first frame after reset is never swapped.
- R8: With scrambling on and lane sync off, a closing octet equal to 0xFC is output as 0xFC with `out_ctrl` = 1. Any other closing octet passes unchanged, whether or not it repeats.
- R9: With scrambling on and lane sync on, a closing octet of 0xFC that is not at a multiframe end becomes a control 0xFC. A closing octet of 0x7C at a multiframe end becomes a control 0x7C. Every other octet, including 0xFC at a multiframe end and 0x7C elsewhere, passes as data.
- R10: A multiframe end is the closing octet of every `MF_FRAMES`-th frame (1 to 32), counting valid frames only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input octet qualifier |
| in_data | input | 8 | Input data octet |
| in_scr_en | input | 1 | Scrambling mode enable |
| in_lsync_en | input | 1 | Lane-sync mode enable |
| out_valid | output | 1 | Output octet qualifier |
| out_data | output | 8 | Output octet (data or control character) |
| out_ctrl | output | 1 | Output octet is a control character |

## Verification
Repeat detection and multiframe-end character selection can land on the same octet. So can a swap and the loading of the history register with the original value, which the next frame's comparison depends on. The bench builds a short multiframe and biases closing octets toward repeats of the previous closing octet and toward 0xFC and 0x7C. It also inserts idle cycles and changes modes between segments. Each output is judged against a bench model that tracks position and history on its own, including runs of three identical frames in which the middle one was swapped.

// File: rtl/fai_pkg.sv
package fai_pkg;

    typedef logic [7:0] octet_t;

    localparam octet_t CH_FRAME = 8'hFC;
    localparam octet_t CH_MULTI = 8'h7C;

    typedef struct packed {
        logic frame_end;
        logic mf_end;
    } pos_t;

    typedef struct packed {
        logic   valid;
        logic   ctrl;
        octet_t data;
    } lane_word_t;

    typedef enum logic [1:0] {
        MODE_RAW_FREE  = 2'b00,
        MODE_RAW_SYNC  = 2'b01,
        MODE_SCR_FREE  = 2'b10,
        MODE_SCR_SYNC  = 2'b11
    } ins_mode_e;

    function automatic ins_mode_e mode_of(input logic scr, input logic sync);
        return ins_mode_e'({scr, sync});
    endfunction

endpackage

// File: rtl/fai_position.sv
module fai_position
    import fai_pkg::*;
#(
    parameter int FRAME_OCTETS = 2,
    parameter int MF_FRAMES    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output pos_t pos
);
    localparam int OW = (FRAME_OCTETS > 1) ? $clog2(FRAME_OCTETS) : 1;
    localparam int FW = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1;

    logic [OW-1:0] oct_idx;
    logic [FW-1:0] fr_idx;
    logic          fend;
    logic          mend;

    generate
        if (FRAME_OCTETS > 1) begin : g_oct
            assign fend = (oct_idx == OW'(FRAME_OCTETS - 1));
            always_ff @(posedge clk) begin
                if (rst)
                    oct_idx <= '0;
                else if (adv)
                    oct_idx <= fend ? '0 : oct_idx + 1'b1;
            end
        end else begin : g_oct1
            assign fend = 1'b1;
            always_ff @(posedge clk) oct_idx <= '0;
        end

        if (MF_FRAMES > 1) begin : g_fr
            logic last_fr;
            assign last_fr = (fr_idx == FW'(MF_FRAMES - 1));
            assign mend    = fend && last_fr;
            always_ff @(posedge clk) begin
                if (rst)
                    fr_idx <= '0;
                else if (adv && fend)
                    fr_idx <= last_fr ? '0 : fr_idx + 1'b1;
            end
        end else begin : g_fr1
            assign mend = fend;
            always_ff @(posedge clk) fr_idx <= '0;
        end
    endgenerate

    assign pos.frame_end = fend;
    assign pos.mf_end    = mend;

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(oct_idx) < FRAME_OCTETS) && (int'(fr_idx) < MF_FRAMES)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(oct_idx) && $stable(fr_idx)); // R3

endmodule

// File: rtl/fai_history.sv
module fai_history
    import fai_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  octet_t din,
    output octet_t prev,
    output logic   prev_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else if (load) begin
            prev    <= din;
            prev_ok <= 1'b1;
        end
    end

    AST_HIST_ORIGINAL: assert property (@(posedge clk) disable iff (rst)
        load |=> (prev == $past(din)) && prev_ok); // R6

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(prev)); // R3

endmodule

// File: rtl/fai_select.sv
module fai_select
    import fai_pkg::*;
(
    input  logic   scr_en,
    input  logic   lsync_en,
    input  pos_t   pos,
    input  octet_t din,
    input  octet_t prev,
    input  logic   prev_ok,
    output logic   ctrl,
    output octet_t dout
);
    ins_mode_e mode;
    logic      repeat_hit;

    assign mode       = mode_of(scr_en, lsync_en);
    assign repeat_hit = prev_ok && (din == prev);

    always_comb begin
        ctrl = 1'b0;
        dout = din;
        if (pos.frame_end) begin
            unique case (mode)
                MODE_RAW_FREE: begin
                    if (repeat_hit) begin
                        ctrl = 1'b1;
                        dout = CH_FRAME;
                    end
                end
                MODE_RAW_SYNC: begin
                    if (repeat_hit) begin
                        ctrl = 1'b1;
                        dout = pos.mf_end ? CH_MULTI : CH_FRAME;
                    end
                end
                MODE_SCR_FREE: begin
                    ctrl = (din == CH_FRAME);
                end
                MODE_SCR_SYNC: begin
                    ctrl = pos.mf_end ? (din == CH_MULTI) : (din == CH_FRAME);
                end
                default: ctrl = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fai_inserter.sv
module fai_inserter
    import fai_pkg::*;
#(
    parameter int FRAME_OCTETS = 2,
    parameter int MF_FRAMES    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_scr_en,
    input  logic       in_lsync_en,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_ctrl
);
    pos_t       pos;
    octet_t     prev;
    logic       prev_ok;
    logic       sel_ctrl;
    octet_t     sel_data;
    lane_word_t out_q;
    pos_t       pos_q;
    logic       lsync_q;
    logic       scr_q;

    fai_position #(
        .FRAME_OCTETS (FRAME_OCTETS),
        .MF_FRAMES    (MF_FRAMES)
    ) u_pos (
        .clk (clk),
        .rst (rst),
        .adv (in_valid),
        .pos (pos)
    );

    fai_history u_hist (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid && pos.frame_end),
        .din     (in_data),
        .prev    (prev),
        .prev_ok (prev_ok)
    );

    fai_select u_sel (
        .scr_en   (in_scr_en),
        .lsync_en (in_lsync_en),
        .pos      (pos),
        .din      (in_data),
        .prev     (prev),
        .prev_ok  (prev_ok),
        .ctrl     (sel_ctrl),
        .dout     (sel_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            pos_q   <= '0;
            lsync_q <= 1'b0;
            scr_q   <= 1'b0;
        end else begin
            out_q.valid <= in_valid;
            if (in_valid) begin
                out_q.ctrl <= sel_ctrl;
                out_q.data <= sel_data;
                pos_q      <= pos;
                lsync_q    <= in_lsync_en;
                scr_q      <= in_scr_en;
            end
        end
    end

    assign out_valid = out_q.valid;
    assign out_ctrl  = out_q.ctrl;
    assign out_data  = out_q.data;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !out_valid && !out_ctrl); // R1

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R3

    AST_CTRL_AT_END: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl) |-> pos_q.frame_end); // R2

    AST_CTRL_CHARSET: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl) |-> (out_data == CH_FRAME || out_data == CH_MULTI)); // R4

    AST_MULTI_CHAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl && out_data == CH_MULTI) |-> (pos_q.mf_end && lsync_q)); // R5

    AST_SCR_FREE_FRAME: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl && scr_q && !lsync_q) |-> (out_data == CH_FRAME)); // R8

endmodule

// File: tb/fai_inserter_bench.sv
module fai_inserter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int KF         = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_scr_en;
    logic       in_lsync_en;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ctrl;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model state
    int       m_oct;
    int       m_fr;
    bit [7:0] m_prev;
    bit       m_prev_ok;
    // pending expectation
    bit       e_pend;
    bit       e_valid;
    bit       e_ctrl;
    bit [7:0] e_data;
    string    e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    fai_inserter #(.FRAME_OCTETS(2), .MF_FRAMES(KF)) u_fai_inserter (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_scr_en   (in_scr_en),
        .in_lsync_en (in_lsync_en),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_ctrl    (out_ctrl)
    );

    // expected {ctrl, data} written from the requirement table
    function automatic bit [8:0] model_out(bit scr, bit sync, bit fend, bit mend,
                                            bit [7:0] d, bit [7:0] p, bit pok);
        bit rep;
        rep = pok && (d == p);
        if (!fend) return {1'b0, d};
        if (!scr && !sync) return rep ? {1'b1, 8'hFC} : {1'b0, d};       // R4
        if (!scr && sync) begin                                           // R5
            if (!rep) return {1'b0, d};
            return mend ? {1'b1, 8'h7C} : {1'b1, 8'hFC};
        end
        if (!sync) return (d == 8'hFC) ? {1'b1, 8'hFC} : {1'b0, d};       // R8
        if (mend) return (d == 8'h7C) ? {1'b1, 8'h7C} : {1'b0, d};        // R9
        return (d == 8'hFC) ? {1'b1, 8'hFC} : {1'b0, d};                  // R9
    endfunction

    task automatic note(bit ok, string tag, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic check_pending();
        if (!e_pend) return;
        if (!e_valid) begin
            note(out_valid == 1'b0, "R3",
                 $sformatf("out_valid act=%0b exp=0", out_valid));
        end else begin
            note(out_valid && out_ctrl == e_ctrl && out_data == e_data, e_tag,
                 $sformatf("act v=%0b c=%0b d=%02h exp v=1 c=%0b d=%02h",
                           out_valid, out_ctrl, out_data, e_ctrl, e_data));
        end
        e_pend = 0;
    endtask

    task automatic model_reset();
        m_oct = 0; m_fr = 0; m_prev = 8'h00; m_prev_ok = 0; e_pend = 0;
    endtask

    // drive at negedge; check the previous cycle's result first
    task automatic step(bit v, bit [7:0] d, bit scr, bit sync);
        bit fend, mend;
        bit [8:0] r;
        @(negedge clk);
        check_pending();
        in_valid = v; in_data = d; in_scr_en = scr; in_lsync_en = sync;
        e_pend = 1; e_valid = v;
        if (v) begin
            fend = (m_oct == 1);
            mend = fend && (m_fr == KF - 1);
            r = model_out(scr, sync, fend, mend, d, m_prev, m_prev_ok);
            e_ctrl = r[8]; e_data = r[7:0];
            if (!fend)                   e_tag = "R2";
            else if (!scr && !m_prev_ok) e_tag = "R7";
            else if (mend)               e_tag = scr ? (sync ? "R9_R10" : "R8_R10") : (sync ? "R5_R10" : "R4_R10");
            else                         e_tag = scr ? (sync ? "R9" : "R8") : (sync ? "R5_R6" : "R4_R6");
            if (fend) begin
                m_prev = d; m_prev_ok = 1;
                m_fr = (m_fr == KF - 1) ? 0 : m_fr + 1;
            end
            m_oct = fend ? 0 : 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_pending();
        rst = 1; in_valid = 0;
        repeat (2) begin
            @(negedge clk);
            note(!out_valid && !out_ctrl, "R1",
                 $sformatf("reset outputs v=%0b c=%0b exp 0 0", out_valid, out_ctrl));
        end
        rst = 0;
        model_reset();
    endtask

    task automatic frame(bit [7:0] hi, bit [7:0] lo, bit scr, bit sync);
        step(1, hi, scr, sync);
        step(1, lo, scr, sync);
    endtask

    initial begin
        rst = 1; in_valid = 0; in_data = 0; in_scr_en = 0; in_lsync_en = 0;
        model_reset();
        void'($urandom(32'd20240611));
        do_reset();

        // R7: first frame closing octet not swapped; then R4 repeat
        frame(8'h11, 8'hFC, 0, 0);
        frame(8'h22, 8'hFC, 0, 0);
        // R6: run of identical closers after a swap
        frame(8'h33, 8'hFC, 0, 0);
        frame(8'h44, 8'h55, 0, 0);
        // R3: idle cycles mid-frame, position preserved
        step(1, 8'h66, 0, 1);
        step(0, 8'h55, 0, 1);
        step(0, 8'h55, 0, 1);
        step(1, 8'h55, 0, 1);
        // R5/R10: repeat at multiframe end gives 0x7C
        frame(8'h01, 8'h55, 0, 1);
        frame(8'h02, 8'h55, 0, 1);
        frame(8'h03, 8'h55, 0, 1);
        // R9: scrambled with sync, both characters at both positions
        frame(8'h04, 8'hFC, 1, 1);
        frame(8'h05, 8'h7C, 1, 1);
        frame(8'h06, 8'hFC, 1, 1);
        frame(8'h07, 8'h7C, 1, 1);
        frame(8'h08, 8'h7C, 1, 1);
        frame(8'h09, 8'h11, 1, 1);
        frame(8'h0A, 8'hFC, 1, 1);
        frame(8'h0B, 8'hFC, 1, 1);
        // R8: scrambled without sync, repeat ignored
        frame(8'h0C, 8'h7C, 1, 0);
        frame(8'h0D, 8'h7C, 1, 0);
        frame(8'h0E, 8'hFC, 1, 0);

        // R7 again after a mid-run reset
        do_reset();
        frame(8'hA0, 8'h00, 0, 1);
        frame(8'hA1, 8'h00, 0, 1);

        // constrained random segments
        for (int seg = 0; seg < 40; seg++) begin
            bit scr, sync;
            scr  = $urandom_range(0, 1);
            sync = $urandom_range(0, 1);
            for (int i = 0; i < 64; i++) begin
                int sel;
                bit v;
                bit [7:0] d;
                v   = ($urandom_range(0, 9) < 8);
                sel = $urandom_range(0, 9);
                if (sel < 3)      d = m_prev;
                else if (sel < 5) d = 8'hFC;
                else if (sel < 7) d = 8'h7C;
                else              d = 8'($urandom);
                step(v, d, scr, sync);
            end
        end

        @(negedge clk);
        check_pending();
        in_valid = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule